// File: doc/BRIEF.md
# Counted Block Accumulator and Averager

This block sums a stream of signed samples in fixed-size blocks. A valid strobe marks each sample. An internal counter tracks how many samples the open block holds. The block size is 2^n samples, and n is a parameter.

When the last sample of a block arrives, the block does four things on that same clock edge:
- it latches the block total, including that last sample, into the sum output;
- it latches the total with its n low bits dropped into the average output;
- it clears the accumulator, so the next sample starts a fresh block;
- it raises a one-cycle done pulse in the following cycle.

A flush input closes a partial block early. A flushed block reports its sum and its sample count, and it marks its average as not valid.

Top module: `block_averager`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the sample counter and every output: `sum_out`, `avg_out`, `avg_valid`, `count_out` and `done` all read 0. A block that was open when reset arrived is discarded.
- R2: Only cycles with `in_valid` high add `in_sample` to the accumulator and advance the sample counter. On cycles with `in_valid` low, the sample value has no effect.
- R3: On the clock edge that accepts the 2^n-th valid sample of a block, `sum_out` takes the exact signed total of the block's samples. `done` is then 1 for the following cycle only, unless another block closes on the next edge.
- R4: When a full block closes, `avg_out` equals the total shifted arithmetically right by n (floor of the mean, SAMPLE_W bits wide), `avg_valid` is 1 and `count_out` equals 2^n.
- R5: The edge that closes a block also clears the accumulator. A valid sample in the very next cycle starts the next block, so back-to-back blocks lose no sample.
- R6: `sum_out`, `avg_out`, `avg_valid` and `count_out` hold their values in every cycle where `done` is low.
- R7: `flush` high closes an open block that holds at least one sample, counting any valid sample in the same cycle. In the cycle after, `sum_out` shows the partial total, `count_out` the sample count (1 to 2^n-1), `avg_valid` is 0, `avg_out` is 0, and `done` pulses.
- R8: `flush` high while the open block holds no sample and `in_valid` is low has no effect. `done` stays low and all outputs hold.
- R9: `flush` in the same cycle as the 2^n-th valid sample closes a full block, with `avg_valid` 1 and `count_out` 2^n.
- R10: The accumulator is n bits wider than a sample, so no block overflows. A block made only of the most negative sample gives `sum_out` = -2^(SAMPLE_W-1) * 2^n and `avg_out` = -2^(SAMPLE_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SAMPLE_W | Signed sample, two's complement |
| flush | input | 1 | Close the open block early |
| sum_out | output | SAMPLE_W+LOG2_BLOCK | Signed total of the last closed block |
| avg_out | output | SAMPLE_W | Total shifted right by LOG2_BLOCK; 0 after a partial block |
| avg_valid | output | 1 | Last closed block was full |
| count_out | output | LOG2_BLOCK+1 | Samples in the last closed block |
| done | output | 1 | One-cycle pulse when outputs update |

## Verification
The bench tries the main function with several input patterns, and each one separates a different fault:
- Small positive samples spread over idle cycles that carry junk values show whether idle cycles leak into the total or advance the counter.
- Uninterrupted runs of blocks show whether the clear loses or double-counts the sample at a block boundary.
- Negative and most-negative blocks show whether the average rounds toward minus infinity through an arithmetic shift, and whether the wide total keeps its sign.
- Flushes are applied in three positions: mid-block, on an empty block, and on the final sample. They show whether partial blocks report their count, whether empty flushes are ignored, and whether a flush on the last sample still counts as a full block.

// File: rtl/block_averager.sv
module block_averager #(
  parameter int SAMPLE_W   = 8,
  parameter int LOG2_BLOCK = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid,
  input  logic signed [SAMPLE_W-1:0]           in_sample,
  input  logic                                 flush,
  output logic signed [SAMPLE_W+LOG2_BLOCK-1:0] sum_out,
  output logic signed [SAMPLE_W-1:0]           avg_out,
  output logic                                 avg_valid,
  output logic [LOG2_BLOCK:0]                  count_out,
  output logic                                 done
);
  localparam int ACC_W = SAMPLE_W + LOG2_BLOCK;
  localparam int CNT_W = LOG2_BLOCK + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'((1 << LOG2_BLOCK) - 1);

  logic signed [ACC_W-1:0] acc;
  logic [CNT_W-1:0]        cnt;

  logic signed [ACC_W-1:0] addend, total, shifted;
  logic [CNT_W-1:0]        next_cnt;
  logic                    full, close;

  assign addend   = in_valid ? {{LOG2_BLOCK{in_sample[SAMPLE_W-1]}}, in_sample} : '0;
  assign total    = acc + addend;
  assign next_cnt = cnt + CNT_W'(in_valid);
  assign full     = in_valid && (cnt == LAST);
  assign close    = full || (flush && next_cnt != '0);
  assign shifted  = total >>> LOG2_BLOCK;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      cnt       <= '0;
      sum_out   <= '0;
      avg_out   <= '0;
      avg_valid <= 1'b0;
      count_out <= '0;
      done      <= 1'b0;
    end else begin
      done <= close;
      if (close) begin
        acc       <= '0;
        cnt       <= '0;
        sum_out   <= total;
        avg_out   <= full ? shifted[SAMPLE_W-1:0] : '0;
        avg_valid <= full;
        count_out <= next_cnt;
      end else begin
        acc <= total;
        cnt <= next_cnt;
      end
    end
  end
endmodule

module block_averager_chk #(
  parameter int SAMPLE_W   = 8,
  parameter int LOG2_BLOCK = 2
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic                                 in_valid,
  input logic                                 flush,
  input logic signed [SAMPLE_W+LOG2_BLOCK-1:0] sum_out,
  input logic signed [SAMPLE_W-1:0]           avg_out,
  input logic                                 avg_valid,
  input logic [LOG2_BLOCK:0]                  count_out,
  input logic                                 done
);
  localparam int BLOCK = 1 << LOG2_BLOCK;
  int seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= 0;
    else if ((in_valid && seen == BLOCK - 1) || (flush && (seen + int'(in_valid)) != 0)) seen <= 0;
    else if (in_valid) seen <= seen + 1;
  end

  assert_full_close_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && seen == BLOCK - 1) |=> (done && avg_valid));

  assert_full_count_R4: assert property (@(posedge clk) disable iff (rst)
    (done && avg_valid) |-> (count_out == (LOG2_BLOCK+1)'(BLOCK)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> ($stable(sum_out) && $stable(avg_out) && $stable(count_out) && $stable(avg_valid)));

  assert_partial_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !avg_valid) |-> (count_out != '0 && count_out < (LOG2_BLOCK+1)'(BLOCK) && avg_out == '0));

  assert_empty_flush_R8: assert property (@(posedge clk) disable iff (rst)
    (flush && !in_valid && seen == 0) |=> !done);

  assert_no_idle_close_R2: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !flush) |=> !done);
endmodule

bind block_averager block_averager_chk #(.SAMPLE_W(SAMPLE_W), .LOG2_BLOCK(LOG2_BLOCK)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .flush(flush), .sum_out(sum_out),
  .avg_out(avg_out), .avg_valid(avg_valid), .count_out(count_out), .done(done)
);

// File: tb/test_block_averager.sv
module test_block_averager;
  localparam int SW = 8;
  localparam int LB = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [SW-1:0] in_sample = '0;
  logic flush = 1'b0;
  logic signed [SW+LB-1:0] sum_out;
  logic signed [SW-1:0] avg_out;
  logic avg_valid;
  logic [LB:0] count_out;
  logic done;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  block_averager #(.SAMPLE_W(SW), .LOG2_BLOCK(LB)) i_block_averager (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample), .flush(flush),
    .sum_out(sum_out), .avg_out(avg_out), .avg_valid(avg_valid),
    .count_out(count_out), .done(done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input int s, input logic f);
    @(negedge clk);
    in_valid  = v;
    in_sample = SW'(s);
    flush     = f;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    flush    = 1'b0;
  endtask

  task automatic expect_block(input string tag, input int sum, input int avg,
                              input int av, input int cnt);
    chk({tag, " done"}, longint'(done), 1);
    chk({tag, " sum"}, longint'(sum_out), sum);
    chk({tag, " avg"}, longint'(avg_out), avg);
    chk({tag, " avg_valid"}, longint'(avg_valid), av);
    chk({tag, " count"}, longint'(count_out), cnt);
  endtask

  task automatic t_reset();
    chk("R1 reset sum", longint'(sum_out), 0);
    chk("R1 reset avg", longint'(avg_out), 0);
    chk("R1 reset avg_valid", longint'(avg_valid), 0);
    chk("R1 reset count", longint'(count_out), 0);
    chk("R1 reset done", longint'(done), 0);
  endtask

  task automatic t_gapped_block();
    step(1, 10, 0);
    step(0, 99, 0);
    step(1, -3, 0);
    step(0, -77, 0);
    step(1, 7, 0);
    chk("R2 no close after 3 valid", longint'(done), 0);
    step(0, 55, 0);
    chk("R2 idle junk ignored", longint'(done), 0);
    step(1, 1, 0);
    expect_block("R3 R4 gapped", 15, 3, 1, 4);
    step(0, 0, 0);
    chk("R3 done one cycle", longint'(done), 0);
    chk("R6 sum holds", longint'(sum_out), 15);
    chk("R6 avg holds", longint'(avg_out), 3);
  endtask

  task automatic t_back_to_back();
    for (int i = 1; i <= 4; i++) step(1, i, 0);
    expect_block("R5 first block", 10, 2, 1, 4);
    step(1, 5, 0);
    chk("R5 done drops", longint'(done), 0);
    for (int i = 6; i <= 8; i++) step(1, i, 0);
    expect_block("R5 second block", 26, 6, 1, 4);
  endtask

  task automatic t_negative();
    for (int i = 0; i < 4; i++) step(1, -128, 0);
    expect_block("R10 most negative", -512, -128, 1, 4);
    step(1, -5, 0);
    step(1, -2, 0);
    step(1, 0, 0);
    step(1, 0, 0);
    expect_block("R4 floor negative", -7, -2, 1, 4);
    for (int i = 0; i < 4; i++) step(1, 127, 0);
    expect_block("R10 most positive", 508, 127, 1, 4);
  endtask

  task automatic t_flush_partial();
    step(1, 5, 0);
    step(1, 6, 0);
    step(1, 7, 1);
    expect_block("R7 partial", 18, 0, 0, 3);
    for (int i = 0; i < 4; i++) step(1, 1, 0);
    expect_block("R7 restart after flush", 4, 1, 1, 4);
    step(1, 9, 0);
    step(0, 0, 1);
    expect_block("R7 flush alone", 9, 0, 0, 1);
  endtask

  task automatic t_empty_flush();
    step(0, 42, 1);
    chk("R8 empty flush no done", longint'(done), 0);
    chk("R8 sum holds", longint'(sum_out), 9);
    chk("R8 count holds", longint'(count_out), 1);
    for (int i = 0; i < 4; i++) step(1, 2, 0);
    expect_block("R8 counter untouched", 8, 2, 1, 4);
  endtask

  task automatic t_flush_last();
    step(1, 3, 0);
    step(1, 3, 0);
    step(1, 3, 0);
    step(1, 4, 1);
    expect_block("R9 flush on last", 13, 3, 1, 4);
  endtask

  task automatic t_reset_mid();
    step(1, 50, 0);
    step(1, 50, 0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) step(1, -1, 0);
    expect_block("R1 block dropped by reset", -4, -1, 1, 4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_gapped_block();
    t_back_to_back();
    t_negative();
    t_flush_partial();
    t_empty_flush();
    t_flush_last();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule